// File: doc/BRIEF.md
# Multi-clock stream command controller

This block takes byte-wide commands from a stream slave running in the network clock domain. It turns them into control for two engines that run on clocks of their own: a pulse generator on the DAC clock and a capture engine on the ADC clock. It recognises three single-purpose frames. The first is a one-byte soft reset and the second is a one-byte start. The third is a configuration frame: an opcode byte followed by twelve payload bytes that set the pulse width, the period, the count and the amplitude.

Reset and start become one-cycle strobes in each target domain. The configuration is parsed into a network-side word. That word is then carried into each target domain as a whole, through a request/acknowledge crossing, so no downstream register is ever seen half-written. A start makes the controller busy. It leaves busy only when the capture engine returns a one-cycle completion pulse on the ADC clock. While busy, frames are still drained from the stream but have no effect.

Top module: `strm_cmd_ctrl`

## Requirements
- R1: `s_tready` is 0 while `rst_n` is low and is 1 from the first network clock edge after reset release onward. A byte is taken on a network clock edge where `s_tvalid` and `s_tready` are both 1.
- R2: A one-byte frame holding 0x0F with `s_tlast`=1 yields exactly one `dac_rst_p` pulse and exactly one `adc_rst_p` pulse. At most one of the internal reset, start and load events fires per network cycle.
- R3: A one-byte frame holding 0xF0 with `s_tlast`=1, received while not busy, yields exactly one `dac_start_p` and one `adc_start_p` pulse and makes the controller busy.
- R4: A frame of opcode 0x88 (with `s_tlast`=0) followed by exactly 12 payload bytes, with `s_tlast`=1 only on the twelfth, loads a configuration. The payload is least-significant byte first, forming a 96-bit word. Bits [31:0] are the width, [63:32] the period, [79:64] the count and [95:80] the raw height. `dac_width`, `dac_period` and `dac_count` take those fields, and `dac_height` takes the low DAC_DW bits of the raw height.
- R5: `adc_period` and `adc_count` take the same period and count values as the DAC side for every accepted configuration frame.
- R6: After reset all configuration outputs are 0. Each accepted configuration appears in each domain as one simultaneous change of all that domain's outputs, never as a partial update. Back-to-back frames appear in order.
- R7: While busy, every frame (start, reset, configuration) is consumed with no effect. A one-cycle `adc_done` pulse on the ADC clock ends busy, after which commands act again.
- R8: A first byte that is not one of the three opcodes is ignored. A 0x0F or 0xF0 byte with `s_tlast`=0 is not acted on, and the rest of that frame up to `s_tlast` is dropped.
- R9: A configuration frame whose `s_tlast` comes before the twelfth payload byte, or whose payload runs past twelve bytes, is discarded and leaves all configuration outputs unchanged.
- R10: Every strobe output is high for exactly one cycle of its own domain's clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| net_clk | input | 1 | Network-side clock |
| dac_clk | input | 1 | DAC engine clock |
| adc_clk | input | 1 | ADC engine clock |
| rst_n | input | 1 | Active-low asynchronous reset for all domains |
| s_tdata | input | 8 | Stream byte |
| s_tvalid | input | 1 | Stream byte valid |
| s_tready | output | 1 | Stream ready |
| s_tlast | input | 1 | Last byte of the frame |
| adc_done | input | 1 | Completion pulse, ADC clock |
| dac_width | output | 32 | Pulse width, DAC clock |
| dac_period | output | 32 | Pulse period, DAC clock |
| dac_count | output | 16 | Pulse count, DAC clock |
| dac_height | output | DAC_DW | Pulse amplitude, DAC clock |
| adc_period | output | 32 | Pulse period, ADC clock |
| adc_count | output | 16 | Pulse count, ADC clock |
| dac_rst_p | output | 1 | Reset strobe, DAC clock |
| adc_rst_p | output | 1 | Reset strobe, ADC clock |
| dac_start_p | output | 1 | Start strobe, DAC clock |
| adc_start_p | output | 1 | Start strobe, ADC clock |

## Verification
A strobe is registered in the network domain on the edge after the closing byte is taken. It is toggled on the next network edge and shows in the target domain on the third target-clock edge after that. A configuration adds two network edges for staging and launch before the same three target edges. The acknowledge return keeps a second frame queued until the first has landed. Since the target clocks are unrelated, the bench does not sample at a fixed edge. It records expected events in queues as each frame is sent, and monitors pop and compare them whenever an output changes. After every stimulus it waits a 40-cycle network window, well beyond the worst-case latency at the ADC clock, and then checks that every queue has drained.

// File: rtl/strm_cmd_pkg.sv
package strm_cmd_pkg;
    localparam logic [7:0] OP_RESET  = 8'h0F;
    localparam logic [7:0] OP_START  = 8'hF0;
    localparam logic [7:0] OP_CONFIG = 8'h88;

    localparam int unsigned PAYLOAD_BYTES = 12;
    localparam int unsigned PAYLOAD_BITS  = PAYLOAD_BYTES * 8;

    localparam int unsigned F_WIDTH_LO  = 0;
    localparam int unsigned F_PERIOD_LO = 32;
    localparam int unsigned F_COUNT_LO  = 64;
    localparam int unsigned F_HEIGHT_LO = 80;

    typedef enum logic [1:0] {
        PS_OPCODE  = 2'd0,
        PS_PAYLOAD = 2'd1,
        PS_DRAIN   = 2'd2
    } parse_st_e;
endpackage

// File: rtl/strobe_xfer.sv
module strobe_xfer #(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic src_clk,
    input  logic dst_clk,
    input  logic rst_n,
    input  logic src_pulse,
    output logic dst_pulse
);
    typedef struct packed {
        logic [SYNC_STAGES-1:0] sync;
        logic                   last;
        logic                   pulse;
    } dst_t;

    logic tgl_d, tgl_q;
    dst_t d_d, d_q;

    always_comb begin
        tgl_d = tgl_q ^ src_pulse;
    end

    always_ff @(posedge src_clk or negedge rst_n) begin
        if (!rst_n) tgl_q <= 1'b0;
        else        tgl_q <= tgl_d;
    end

    always_comb begin
        d_d       = d_q;
        d_d.sync  = {d_q.sync[SYNC_STAGES-2:0], tgl_q};
        d_d.last  = d_q.sync[SYNC_STAGES-1];
        d_d.pulse = d_q.sync[SYNC_STAGES-1] ^ d_q.last;
    end

    always_ff @(posedge dst_clk or negedge rst_n) begin
        if (!rst_n) d_q <= '0;
        else        d_q <= d_d;
    end

    assign dst_pulse = d_q.pulse;

    // R10
    strobe_width_chk: assert property (@(posedge dst_clk) disable iff (!rst_n)
        dst_pulse |=> !dst_pulse)
        else $error("strobe longer than one destination cycle");
endmodule

// File: rtl/cfg_xfer.sv
module cfg_xfer #(
    parameter int unsigned W           = 48,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic         src_clk,
    input  logic         dst_clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] data_i,
    output logic [W-1:0] data_o
);
    typedef struct packed {
        logic                   pend;
        logic [W-1:0]           next;
        logic [W-1:0]           hold;
        logic                   req;
        logic [SYNC_STAGES-1:0] ack_sync;
    } src_t;

    typedef struct packed {
        logic [SYNC_STAGES-1:0] sync;
        logic                   seen;
        logic [W-1:0]           data;
    } dst_t;

    src_t s_d, s_q;
    dst_t d_d, d_q;
    logic ack_w;

    assign ack_w = s_q.ack_sync[SYNC_STAGES-1];

    always_comb begin
        s_d          = s_q;
        s_d.ack_sync = {s_q.ack_sync[SYNC_STAGES-2:0], d_q.seen};
        if (s_q.pend && (ack_w == s_q.req)) begin
            s_d.hold = s_q.next;
            s_d.req  = ~s_q.req;
            s_d.pend = 1'b0;
        end
        if (load_i) begin
            s_d.next = data_i;
            s_d.pend = 1'b1;
        end
    end

    always_ff @(posedge src_clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_comb begin
        d_d      = d_q;
        d_d.sync = {d_q.sync[SYNC_STAGES-2:0], s_q.req};
        if (d_q.sync[SYNC_STAGES-1] != d_q.seen) begin
            d_d.data = s_q.hold;
            d_d.seen = d_q.sync[SYNC_STAGES-1];
        end
    end

    always_ff @(posedge dst_clk or negedge rst_n) begin
        if (!rst_n) d_q <= '0;
        else        d_q <= d_d;
    end

    assign data_o = d_q.data;

    // R6
    hold_stable_chk: assert property (@(posedge src_clk) disable iff (!rst_n)
        (s_q.req != ack_w) |=> $stable(s_q.hold))
        else $error("crossing word changed while a request is open");
endmodule

// File: rtl/strm_cmd_parser.sv
module strm_cmd_parser
    import strm_cmd_pkg::*;
#(
    parameter int unsigned KEEP_BITS = 92
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [7:0]           tdata,
    input  logic                 tvalid,
    input  logic                 tlast,
    output logic                 tready,
    input  logic                 done_i,
    output logic                 rst_o,
    output logic                 start_o,
    output logic                 load_o,
    output logic [KEEP_BITS-1:0] word_o
);
    localparam int unsigned IDXW = $clog2(PAYLOAD_BYTES);
    localparam logic [IDXW-1:0] LAST_IDX = IDXW'(PAYLOAD_BYTES - 1);

    typedef struct packed {
        parse_st_e             st;
        logic [IDXW-1:0]       idx;
        logic [PAYLOAD_BITS-1:0] sh;
        logic [KEEP_BITS-1:0]  word;
        logic                  rdy;
        logic                  busy;
        logic                  rst_p;
        logic                  start_p;
        logic                  load_p;
    } st_t;

    st_t n_d, n_q;

    always_comb begin
        n_d         = n_q;
        n_d.rdy     = 1'b1;
        n_d.rst_p   = 1'b0;
        n_d.start_p = 1'b0;
        n_d.load_p  = 1'b0;
        if (done_i) n_d.busy = 1'b0;

        if (n_q.rdy && tvalid) begin
            case (n_q.st)
                PS_OPCODE: begin
                    if (n_q.busy) begin
                        if (!tlast) n_d.st = PS_DRAIN;
                    end else if (tdata == OP_CONFIG && !tlast) begin
                        n_d.st  = PS_PAYLOAD;
                        n_d.idx = '0;
                    end else if (!tlast) begin
                        n_d.st = PS_DRAIN;
                    end else if (tdata == OP_RESET) begin
                        n_d.rst_p = 1'b1;
                    end else if (tdata == OP_START) begin
                        n_d.start_p = 1'b1;
                        n_d.busy    = 1'b1;
                    end
                end
                PS_PAYLOAD: begin
                    n_d.sh = {tdata, n_q.sh[PAYLOAD_BITS-1:8]};
                    if (tlast) begin
                        n_d.st = PS_OPCODE;
                        if (n_q.idx == LAST_IDX) begin
                            n_d.word   = n_d.sh[KEEP_BITS-1:0];
                            n_d.load_p = 1'b1;
                        end
                    end else if (n_q.idx == LAST_IDX) begin
                        n_d.st = PS_DRAIN;
                    end else begin
                        n_d.idx = n_q.idx + 1'b1;
                    end
                end
                default: begin
                    if (tlast) n_d.st = PS_OPCODE;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) n_q <= '0;
        else        n_q <= n_d;
    end

    assign tready  = n_q.rdy;
    assign rst_o   = n_q.rst_p;
    assign start_o = n_q.start_p;
    assign load_o  = n_q.load_p;
    assign word_o  = n_q.word;

    // R1
    rdy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tready |=> tready)
        else $error("ready dropped after reset");

    // R2
    event_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rst_o, start_o, load_o}))
        else $error("more than one command event in a cycle");

    // R3
    start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_o |-> n_q.busy)
        else $error("start issued without entering busy");

    // R7
    busy_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        n_q.busy |=> !(rst_o || start_o || load_o))
        else $error("command acted on while busy");
endmodule

// File: rtl/strm_cmd_ctrl.sv
module strm_cmd_ctrl
    import strm_cmd_pkg::*;
#(
    parameter int unsigned DAC_DW      = 12,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              net_clk,
    input  logic              dac_clk,
    input  logic              adc_clk,
    input  logic              rst_n,
    input  logic [7:0]        s_tdata,
    input  logic              s_tvalid,
    output logic              s_tready,
    input  logic              s_tlast,
    input  logic              adc_done,
    output logic [31:0]       dac_width,
    output logic [31:0]       dac_period,
    output logic [15:0]       dac_count,
    output logic [DAC_DW-1:0] dac_height,
    output logic [31:0]       adc_period,
    output logic [15:0]       adc_count,
    output logic              dac_rst_p,
    output logic              adc_rst_p,
    output logic              dac_start_p,
    output logic              adc_start_p
);
    localparam int unsigned KEEP_BITS = F_HEIGHT_LO + DAC_DW;
    localparam int unsigned DAC_W     = KEEP_BITS;
    localparam int unsigned ADC_W     = 48;
    localparam int unsigned NSTB      = 4;

    logic                 rst_ev, start_ev, load_ev, done_net;
    logic [KEEP_BITS-1:0] word;
    logic [DAC_W-1:0]     dac_word;
    logic [ADC_W-1:0]     adc_word;
    logic [NSTB-1:0]      stb_src, stb_dst;

    strm_cmd_parser #(.KEEP_BITS(KEEP_BITS)) u_parse (
        .clk     (net_clk),
        .rst_n   (rst_n),
        .tdata   (s_tdata),
        .tvalid  (s_tvalid),
        .tlast   (s_tlast),
        .tready  (s_tready),
        .done_i  (done_net),
        .rst_o   (rst_ev),
        .start_o (start_ev),
        .load_o  (load_ev),
        .word_o  (word)
    );

    strobe_xfer #(.SYNC_STAGES(SYNC_STAGES)) u_done (
        .src_clk   (adc_clk),
        .dst_clk   (net_clk),
        .rst_n     (rst_n),
        .src_pulse (adc_done),
        .dst_pulse (done_net)
    );

    // channel 0: dac reset, 1: adc reset, 2: dac start, 3: adc start
    assign stb_src = {start_ev, start_ev, rst_ev, rst_ev};

    for (genvar i = 0; i < NSTB; i++) begin : g_stb
        if ((i % 2) == 0) begin : g_dac
            strobe_xfer #(.SYNC_STAGES(SYNC_STAGES)) u_x (
                .src_clk (net_clk), .dst_clk (dac_clk), .rst_n (rst_n),
                .src_pulse (stb_src[i]), .dst_pulse (stb_dst[i])
            );
        end else begin : g_adc
            strobe_xfer #(.SYNC_STAGES(SYNC_STAGES)) u_x (
                .src_clk (net_clk), .dst_clk (adc_clk), .rst_n (rst_n),
                .src_pulse (stb_src[i]), .dst_pulse (stb_dst[i])
            );
        end
    end

    assign dac_rst_p   = stb_dst[0];
    assign adc_rst_p   = stb_dst[1];
    assign dac_start_p = stb_dst[2];
    assign adc_start_p = stb_dst[3];

    cfg_xfer #(.W(DAC_W), .SYNC_STAGES(SYNC_STAGES)) u_dac_cfg (
        .src_clk (net_clk),
        .dst_clk (dac_clk),
        .rst_n   (rst_n),
        .load_i  (load_ev),
        .data_i  (word),
        .data_o  (dac_word)
    );

    cfg_xfer #(.W(ADC_W), .SYNC_STAGES(SYNC_STAGES)) u_adc_cfg (
        .src_clk (net_clk),
        .dst_clk (adc_clk),
        .rst_n   (rst_n),
        .load_i  (load_ev),
        .data_i  (word[F_COUNT_LO+15:F_PERIOD_LO]),
        .data_o  (adc_word)
    );

    assign dac_width  = dac_word[F_WIDTH_LO+31:F_WIDTH_LO];
    assign dac_period = dac_word[F_PERIOD_LO+31:F_PERIOD_LO];
    assign dac_count  = dac_word[F_COUNT_LO+15:F_COUNT_LO];
    assign dac_height = dac_word[F_HEIGHT_LO+DAC_DW-1:F_HEIGHT_LO];
    assign adc_period = adc_word[31:0];
    assign adc_count  = adc_word[47:32];
endmodule

// File: tb/sim_strm_cmd_ctrl.sv
`timescale 1ns/1ps
module sim_strm_cmd_ctrl;
    logic        net_clk = 0, dac_clk = 0, adc_clk = 0, rst_n = 0;
    logic [7:0]  s_tdata = 0;
    logic        s_tvalid = 0, s_tlast = 0, adc_done = 0;
    logic        s_tready;
    logic [31:0] dac_width, dac_period, adc_period;
    logic [15:0] dac_count, adc_count;
    logic [11:0] dac_height;
    logic        dac_rst_p, adc_rst_p, dac_start_p, adc_start_p;

    strm_cmd_ctrl u0 (.*);

    always #4.0   net_clk = ~net_clk;
    always #3.846 dac_clk = ~dac_clk;
    always #7.692 adc_clk = ~adc_clk;

    int  nchk = 0, nfail = 0;
    bit  busy_m = 0, done_f = 0;
    string q_drst[$], q_arst[$], q_dstart[$], q_astart[$];
    logic [91:0] q_dcfg[$];
    logic [47:0] q_acfg[$];
    logic [91:0] last_d = '0;
    logic [47:0] last_a = '0;
    bit pv_drst = 0, pv_arst = 0, pv_dst = 0, pv_ast = 0;

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [95:0] act, input logic [95:0] exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s %s: act=%h exp=%h", tag, what, act, exp);
        end
    endtask

    task automatic send_byte(input logic [7:0] b, input bit last);
        @(negedge net_clk);
        s_tdata = b; s_tvalid = 1; s_tlast = last;
        @(posedge net_clk);
        while (!s_tready) @(posedge net_clk);
    endtask

    task automatic idle();
        @(negedge net_clk);
        s_tvalid = 0; s_tlast = 0; s_tdata = 0;
    endtask

    task automatic settle();
        repeat (40) @(posedge net_clk);
    endtask

    task automatic cmd(input logic [7:0] op, input string tag);
        if (!busy_m && op == 8'h0F) begin
            q_drst.push_back(tag); q_arst.push_back(tag);
        end else if (!busy_m && op == 8'hF0) begin
            q_dstart.push_back(tag); q_astart.push_back(tag);
            busy_m = 1;
        end
        send_byte(op, 1);
        idle();
    endtask

    // nbytes payload bytes; valid only when exactly 12
    task automatic send_cfg(input logic [31:0] w, input logic [31:0] p,
                            input logic [15:0] c, input logic [15:0] h,
                            input int nbytes);
        logic [95:0] pl;
        pl = {h, c, p, w};
        if (nbytes == 12 && !busy_m) begin
            q_dcfg.push_back({h[11:0], c, p, w});
            q_acfg.push_back({c, p});
        end
        send_byte(8'h88, 0);
        for (int i = 0; i < nbytes; i++)
            send_byte((i < 12) ? pl[i*8 +: 8] : 8'hA5, i == nbytes - 1);
        idle();
    endtask

    task automatic finish_pulse();
        @(negedge adc_clk); adc_done = 1;
        @(negedge adc_clk); adc_done = 0;
        busy_m = 0;
    endtask

    task automatic drained(input string tag);
        int n;
        n = q_drst.size() + q_arst.size() + q_dstart.size() + q_astart.size()
          + q_dcfg.size() + q_acfg.size();
        chk(n == 0, tag, "expected events still pending", n, 0);
    endtask

    // monitors, DAC domain
    always @(negedge dac_clk) if (rst_n) begin
        if (dac_rst_p) begin
            if (q_drst.size() == 0) chk(0, "R2", "unexpected dac_rst", 1, 0);
            else chk(1, q_drst.pop_front(), "dac_rst", 1, 1);
            chk(!pv_drst, "R10", "dac_rst width", 2, 1);
        end
        if (dac_start_p) begin
            if (q_dstart.size() == 0) chk(0, "R7", "unexpected dac_start", 1, 0);
            else chk(1, q_dstart.pop_front(), "dac_start", 1, 1);
            chk(!pv_dst, "R10", "dac_start width", 2, 1);
        end
        pv_drst = dac_rst_p; pv_dst = dac_start_p;
        if ({dac_height, dac_count, dac_period, dac_width} != last_d) begin
            last_d = {dac_height, dac_count, dac_period, dac_width};
            if (q_dcfg.size() == 0) chk(0, "R6", "unexpected dac cfg change", last_d, 0);
            else begin
                logic [91:0] e;
                e = q_dcfg.pop_front();
                chk(last_d == e, "R4", "dac cfg", last_d, e);
            end
        end
    end

    // monitors, ADC domain
    always @(negedge adc_clk) if (rst_n) begin
        if (adc_rst_p) begin
            if (q_arst.size() == 0) chk(0, "R2", "unexpected adc_rst", 1, 0);
            else chk(1, q_arst.pop_front(), "adc_rst", 1, 1);
            chk(!pv_arst, "R10", "adc_rst width", 2, 1);
        end
        if (adc_start_p) begin
            if (q_astart.size() == 0) chk(0, "R7", "unexpected adc_start", 1, 0);
            else chk(1, q_astart.pop_front(), "adc_start", 1, 1);
            chk(!pv_ast, "R10", "adc_start width", 2, 1);
        end
        pv_arst = adc_rst_p; pv_ast = adc_start_p;
        if ({adc_count, adc_period} != last_a) begin
            last_a = {adc_count, adc_period};
            if (q_acfg.size() == 0) chk(0, "R6", "unexpected adc cfg change", last_a, 0);
            else begin
                logic [47:0] e;
                e = q_acfg.pop_front();
                chk(last_a == e, "R5", "adc cfg", last_a, e);
            end
        end
    end

    initial begin
        repeat (150000) @(posedge net_clk);
        if (!done_f) begin
            nfail++;
            $display("FAIL watchdog: act=running exp=finished");
            $display("  [TB] %0d tests run, %0d failed", nchk, nfail);
            $finish;
        end
    end

    initial begin
        repeat (6) @(negedge net_clk);
        chk(s_tready == 0, "R1", "tready in reset", s_tready, 0);
        chk({dac_width, dac_period, dac_count, dac_height, adc_period, adc_count} == 0,
            "R6", "cfg outputs in reset", dac_width, 0);
        rst_n = 1;
        @(posedge net_clk); @(negedge net_clk);
        chk(s_tready == 1, "R1", "tready after reset", s_tready, 1);

        cmd(8'h0F, "R2"); settle(); drained("R2");

        send_cfg(32'h11223344, 32'h55667788, 16'hA1B2, 16'hFCDE, 12);
        settle(); drained("R4");

        cmd(8'h55, "R8");
        send_byte(8'h0F, 0); send_byte(8'hF0, 1); idle();
        send_byte(8'hF0, 0); send_byte(8'h0F, 1); idle();
        settle(); drained("R8");

        send_cfg(32'hDEAD0001, 32'hDEAD0002, 16'hDEAD, 16'h0123, 5);
        send_cfg(32'hBEEF0001, 32'hBEEF0002, 16'hBEEF, 16'h0456, 13);
        settle(); drained("R9");
        send_cfg(32'h0000_0010, 32'h0000_0400, 16'h0007, 16'h0FFF, 12);
        settle(); drained("R9");

        send_cfg(32'hA0A0_0001, 32'hB0B0_0002, 16'h0101, 16'h0202, 12);
        send_cfg(32'hC0C0_0003, 32'hD0D0_0004, 16'h0303, 16'h0404, 12);
        settle(); drained("R6");

        cmd(8'hF0, "R3"); settle(); drained("R3");
        cmd(8'hF0, "R7"); cmd(8'h0F, "R7");
        send_cfg(32'h7777_7777, 32'h8888_8888, 16'h9999, 16'h0AAA, 12);
        settle(); drained("R7");

        finish_pulse(); settle();
        cmd(8'h0F, "R7");
        send_cfg(32'h0000_0020, 32'h0000_0800, 16'h0003, 16'h0555, 12);
        cmd(8'hF0, "R7");
        settle(); drained("R7");
        finish_pulse(); settle();

        done_f = 1;
        $display("  [TB] %0d tests run, %0d failed", nchk, nfail);
        $finish;
    end
endmodule